// File: doc/BRIEF.md
# Segment Relocation and Protection Unit

This unit sits between a processor's address generation and the memory system. Every access names a segment and an offset. The offset is called the virtual address. Each segment owns a start register and a length register. For a user-mode access the unit confirms that the offset lies inside the segment's length. It then adds the segment's start to form the physical address. An offset outside the segment, or a sum too large for the physical address width, produces a protection fault instead of an address. Kernel-mode accesses skip both relocation and checking and reach any location directly.

The start and length registers are loaded through a separate configuration port. Only a kernel-mode write changes them. A user-mode write attempt is dropped and flagged. Separate segments (for example code, data, heap and stack) each map to their own place in physical memory. Results are registered, so each request is answered one cycle later.

Top module: `bb_guard`

## Requirements
- R1: A user-mode request on segment s with offset v, where v is below the length of s and base(s)+v fits in PA_W bits, gives rsp_valid_o=1, rsp_fault_o=0, rsp_cause_o=1 and rsp_paddr_o=base(s)+v in the cycle after the request.
- R2: Each of the NUM_SEG segments has its own start and length registers. req_seg_i selects the pair used by a request, and a configuration write to one segment leaves every other segment's translation unchanged.
- R3: A user-mode request with offset v greater than or equal to the selected segment's length gives rsp_fault_o=1, rsp_valid_o=0, rsp_cause_o=2 and rsp_paddr_o=0 one cycle later.
- R4: A user-mode request within the segment's length whose sum base(s)+v reaches 2^PA_W or more gives rsp_fault_o=1, rsp_valid_o=0, rsp_cause_o=3 and rsp_paddr_o=0. The length check takes priority over this check.
- R5: A kernel-mode request (req_kernel_i=1) never faults. It gives rsp_valid_o=1, rsp_cause_o=1 and rsp_paddr_o equal to the offset zero-extended to PA_W bits.
- R6: A configuration write with cfg_kernel_i=0 leaves all registers unchanged. It raises priv_fault_o for exactly the following cycle. Without such an attempt, priv_fault_o stays low.
- R7: A configuration write with cfg_kernel_i=1 loads cfg_wdata_i into segment cfg_seg_i. cfg_sel_i=0 selects the start register and cfg_sel_i=1 selects the length register. A request in the same cycle still sees the old value, and requests from the next cycle onward see the new value.
- R8: Reset clears every start and length register and all outputs to zero, so any user-mode request before configuration faults with cause 2.
- R9: A cycle without a request gives rsp_valid_o=0, rsp_fault_o=0, rsp_cause_o=0 and rsp_paddr_o=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_vaddr_i | input | VA_W | Offset within the segment |
| req_seg_i | input | SEG_W | Segment select |
| req_kernel_i | input | 1 | Request issued in kernel mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_seg_i | input | SEG_W | Segment to configure |
| cfg_sel_i | input | 1 | 0 = start register, 1 = length register |
| cfg_wdata_i | input | PA_W | Value to write |
| cfg_kernel_i | input | 1 | Write issued in kernel mode |
| rsp_valid_o | output | 1 | Physical address valid |
| rsp_fault_o | output | 1 | Protection violation |
| rsp_cause_o | output | 2 | 0 none, 1 ok, 2 length, 3 overflow |
| rsp_paddr_o | output | PA_W | Physical address, zero unless valid |
| priv_fault_o | output | 1 | Rejected user-mode configuration write |

## Verification
Directed offsets just below and exactly at a segment's length separate a correct strict comparison from an off-by-one. A start value near the top of the physical space, with offsets one below and at the wrap point, separates the overflow fault from a silent wraparound. Same-cycle request and write pairs show whether requests see old or new register contents. Interleaved user and kernel writes show whether privilege gating really blocks updates. Random mixes of segments, modes and write values then stress segment selection and the priority between the two fault causes against a register model kept in the bench.

// File: rtl/bb_guard_pkg.sv
package bb_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_OK    = 2'd1,
    CAUSE_BOUND = 2'd2,
    CAUSE_OVF   = 2'd3
  } cause_e;

  typedef enum logic {
    CFG_BASE  = 1'b0,
    CFG_BOUND = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/bb_seg_regs.sv
module bb_seg_regs
  import bb_guard_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int PA_W    = 14,
  parameter int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             kernel_i,
  input  logic [SEG_W-1:0] wseg_i,
  input  cfg_sel_e         wsel_i,
  input  logic [PA_W-1:0]  wdata_i,
  input  logic [SEG_W-1:0] rseg_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [PA_W-1:0]  rd_bound_o,
  output logic             priv_fault_o
);
  logic [NUM_SEG-1:0][PA_W-1:0] base_q;
  logic [NUM_SEG-1:0][PA_W-1:0] bound_q;
  logic wr_ok;

  assign wr_ok = we_i && kernel_i;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (wr_ok && wseg_i == SEG_W'(g)) begin
        if (wsel_i == CFG_BASE) base_q[g]  <= wdata_i;
        else                    bound_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_base_o  = '0;
    rd_bound_o = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rseg_i == SEG_W'(i)) begin
        rd_base_o  = base_q[i];
        rd_bound_o = bound_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) priv_fault_o <= 1'b0;
    else         priv_fault_o <= we_i && !kernel_i;
  end

  a_r6_user_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !kernel_i) |=> ($stable(base_q) && $stable(bound_q)));

  a_r6_priv_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !kernel_i) |=> priv_fault_o);

  a_r6_priv_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !kernel_i) |=> !priv_fault_o);

  a_r2_idle_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(base_q) && $stable(bound_q)));
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
  import bb_guard_pkg::*;
#(
  parameter int VA_W = 12,
  parameter int PA_W = 14
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  logic            kernel_i,
  input  logic [PA_W-1:0] base_i,
  input  logic [PA_W-1:0] bound_i,
  output logic [PA_W-1:0] paddr_o,
  output cause_e          cause_o
);
  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  off_ext;
  logic [SUM_W-1:0] sum;
  logic             out_of_seg;

  assign off_ext    = PA_W'(vaddr_i);
  assign sum        = {1'b0, base_i} + {1'b0, off_ext};
  assign out_of_seg = off_ext >= bound_i;

  always_comb begin
    if (kernel_i) begin
      paddr_o = off_ext;
      cause_o = CAUSE_OK;
    end else if (out_of_seg) begin
      paddr_o = '0;
      cause_o = CAUSE_BOUND;
    end else if (sum[PA_W]) begin
      paddr_o = '0;
      cause_o = CAUSE_OVF;
    end else begin
      paddr_o = sum[PA_W-1:0];
      cause_o = CAUSE_OK;
    end
  end
endmodule

// File: rtl/bb_guard.sv
module bb_guard
  import bb_guard_pkg::*;
#(
  parameter int VA_W    = 12,
  parameter int PA_W    = 14,
  parameter int NUM_SEG = 4,
  parameter int SEG_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic             req_kernel_i,
  input  logic             cfg_we_i,
  input  logic [SEG_W-1:0] cfg_seg_i,
  input  logic             cfg_sel_i,
  input  logic [PA_W-1:0]  cfg_wdata_i,
  input  logic             cfg_kernel_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_cause_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             priv_fault_o
);
  logic [PA_W-1:0] sel_base, sel_bound, x_paddr;
  cause_e          x_cause;
  logic            x_ok;

  bb_seg_regs #(.NUM_SEG(NUM_SEG), .PA_W(PA_W), .SEG_W(SEG_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .kernel_i     (cfg_kernel_i),
    .wseg_i       (cfg_seg_i),
    .wsel_i       (cfg_sel_e'(cfg_sel_i)),
    .wdata_i      (cfg_wdata_i),
    .rseg_i       (req_seg_i),
    .rd_base_o    (sel_base),
    .rd_bound_o   (sel_bound),
    .priv_fault_o (priv_fault_o)
  );

  bb_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .vaddr_i  (req_vaddr_i),
    .kernel_i (req_kernel_i),
    .base_i   (sel_base),
    .bound_i  (sel_bound),
    .paddr_o  (x_paddr),
    .cause_o  (x_cause)
  );

  assign x_ok = (x_cause == CAUSE_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_cause_o <= CAUSE_NONE;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && x_ok;
      rsp_fault_o <= req_valid_i && !x_ok;
      rsp_cause_o <= req_valid_i ? x_cause : CAUSE_NONE;
      rsp_paddr_o <= (req_valid_i && x_ok) ? x_paddr : '0;
    end
  end

  a_r1_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_valid_o != rsp_fault_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_fault_o && rsp_cause_o == 2'd0));

  a_r3_fault_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_paddr_o == '0 && rsp_cause_o >= 2'd2));

  a_r5_kernel_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kernel_i) |=>
      (rsp_valid_o && rsp_paddr_o == PA_W'($past(req_vaddr_i))));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_kernel_i) |=>
      (!rsp_valid_o || rsp_paddr_o >= PA_W'($past(req_vaddr_i))));
endmodule

// File: tb/bb_guard_bench.sv
`timescale 1ns/1ps
module bb_guard_bench;
  localparam int VA_W    = 12;
  localparam int PA_W    = 14;
  localparam int NUM_SEG = 4;
  localparam int SEG_W   = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_kernel_i = 1'b0;
  logic [VA_W-1:0] req_vaddr_i = '0;
  logic [SEG_W-1:0] req_seg_i = '0, cfg_seg_i = '0;
  logic cfg_we_i = 1'b0, cfg_sel_i = 1'b0, cfg_kernel_i = 1'b0;
  logic [PA_W-1:0] cfg_wdata_i = '0;
  logic rsp_valid_o, rsp_fault_o, priv_fault_o;
  logic [1:0] rsp_cause_o;
  logic [PA_W-1:0] rsp_paddr_o;

  always #2.5 clk_i = ~clk_i;

  bb_guard #(.VA_W(VA_W), .PA_W(PA_W), .NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_bb_guard (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_seg_i(req_seg_i),
    .req_kernel_i(req_kernel_i),
    .cfg_we_i(cfg_we_i), .cfg_seg_i(cfg_seg_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_kernel_i(cfg_kernel_i),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rsp_cause_o(rsp_cause_o),
    .rsp_paddr_o(rsp_paddr_o), .priv_fault_o(priv_fault_o)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [PA_W-1:0] m_base [NUM_SEG];
  logic [PA_W-1:0] m_bound[NUM_SEG];

  bit pend = 1'b0;
  logic e_valid, e_fault, e_priv;
  logic [1:0] e_cause;
  logic [PA_W-1:0] e_paddr;
  string e_tag;

  task automatic check_now();
    checks++;
    if ({rsp_valid_o, rsp_fault_o, rsp_cause_o, rsp_paddr_o} !==
        {e_valid, e_fault, e_cause, e_paddr}) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%0d, expected v=%0b f=%0b c=%0d pa=%0d",
               e_tag, rsp_valid_o, rsp_fault_o, rsp_cause_o, rsp_paddr_o,
               e_valid, e_fault, e_cause, e_paddr);
    end
    checks++;
    if (priv_fault_o !== e_priv) begin
      errors++;
      $display("FAIL R6: priv_fault got %0b expected %0b", priv_fault_o, e_priv);
    end
  endtask

  task automatic step(input logic rv, input logic [VA_W-1:0] va, input logic [SEG_W-1:0] sg,
                      input logic rk, input logic we, input logic [SEG_W-1:0] cs,
                      input logic csel, input logic [PA_W-1:0] wd, input logic ck,
                      input string tag);
    logic [PA_W:0] sum;
    string t;
    @(negedge clk_i);
    if (pend) check_now();
    req_valid_i = rv; req_vaddr_i = va; req_seg_i = sg; req_kernel_i = rk;
    cfg_we_i = we; cfg_seg_i = cs; cfg_sel_i = csel; cfg_wdata_i = wd; cfg_kernel_i = ck;
    sum = {1'b0, m_base[sg]} + (PA_W+1)'(va);
    e_valid = 0; e_fault = 0; e_cause = 0; e_paddr = '0;
    if (!rv) t = "R9";
    else if (rk) begin e_valid = 1; e_cause = 1; e_paddr = PA_W'(va); t = "R5"; end
    else if (PA_W'(va) >= m_bound[sg]) begin e_fault = 1; e_cause = 2; t = "R3"; end
    else if (sum[PA_W]) begin e_fault = 1; e_cause = 3; t = "R4"; end
    else begin e_valid = 1; e_cause = 1; e_paddr = sum[PA_W-1:0]; t = "R1"; end
    e_tag = (tag == "") ? t : tag;
    e_priv = we && !ck;
    if (we && ck) begin
      if (csel) m_bound[cs] = wd;
      else      m_base[cs]  = wd;
    end
    pend = 1'b1;
  endtask

  task automatic acc(input logic [VA_W-1:0] va, input logic [SEG_W-1:0] sg, input string tag);
    step(1'b1, va, sg, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic wr(input logic [SEG_W-1:0] cs, input logic csel, input logic [PA_W-1:0] wd,
                    input logic ck, input string tag);
    step(1'b0, '0, '0, 1'b0, 1'b1, cs, csel, wd, ck, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NUM_SEG; i++) begin m_base[i] = '0; m_bound[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R8: reset state of outputs
    checks++;
    if ({rsp_valid_o, rsp_fault_o, rsp_cause_o, rsp_paddr_o, priv_fault_o} !== '0) begin
      errors++;
      $display("FAIL R8: outputs during reset got %0b%0b %0d %0d %0b expected all zero",
               rsp_valid_o, rsp_fault_o, rsp_cause_o, rsp_paddr_o, priv_fault_o);
    end
    rst_ni = 1'b1;
    acc(12'd0, 2'd0, "R8");
    acc(12'd5, 2'd3, "R8");
    // R6: user write dropped, then visible through an access
    wr(2'd1, 1'b1, 14'd4000, 1'b0, "R6");
    acc(12'd0, 2'd1, "R6");
    // R7: kernel writes
    wr(2'd1, 1'b1, 14'd50, 1'b1, "R7");
    wr(2'd1, 1'b0, 14'd1000, 1'b1, "R7");
    acc(12'd49, 2'd1, "R1");
    acc(12'd50, 2'd1, "R3");
    acc(12'd51, 2'd1, "R3");
    // R7: same-cycle request sees old base
    step(1'b1, 12'd10, 2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 14'd2000, 1'b1, "R7");
    acc(12'd10, 2'd1, "R7");
    // R6: user write of base ignored
    wr(2'd1, 1'b0, 14'd5, 1'b0, "R6");
    acc(12'd10, 2'd1, "R6");
    // R4: overflow near top of space
    wr(2'd2, 1'b1, 14'd100, 1'b1, "R7");
    wr(2'd2, 1'b0, 14'd16374, 1'b1, "R7");
    acc(12'd9, 2'd2, "R4");
    acc(12'd10, 2'd2, "R4");
    acc(12'd200, 2'd2, "R3");
    // R2: segment 1 unchanged by segment 2 writes
    acc(12'd10, 2'd1, "R2");
    // R5: kernel access ignores bound and base
    step(1'b1, 12'd4095, 2'd3, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R5");
    step(1'b1, 12'd60, 2'd1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R5");
    step(1'b0, 12'd7, 2'd1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R9");
    for (int n = 0; n < 3000; n++) begin
      logic rv, we;
      rv = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      step(rv, VA_W'($urandom), SEG_W'($urandom), ($urandom % 5) == 0,
           we, SEG_W'($urandom), 1'($urandom), PA_W'($urandom),
           ($urandom % 4) != 0, "");
    end
    step(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R9");
    @(negedge clk_i);
    check_now();
    summary();
  end
endmodule